// File: doc/BRIEF.md
# Accumulator ALU with Carry

This block is the 8-bit arithmetic and logic stage of an accumulator-based processor. The sequencer presents an operation code, the current accumulator, a second operand and the carry flag, and raises `op_valid`. One clock later the block returns the new accumulator value, the new carry, and `acc_we`, a write-back enable that says whether the register file should store the accumulator result. The sequencer fetches the second operand from a register, from memory or from an immediate byte before presenting it. The block treats all three sources the same way.

The operations are add, add with carry, subtract, subtract with borrow, compare, the three bitwise logic operations, complement of the accumulator, complement of the carry, set carry, and four one-bit rotates. Two rotates pass through the carry as a ninth bit. The other two are 8-bit circular rotates that also copy the bit shifted out into the carry. A separate 16-bit register-pair add produces a 16-bit sum on its own output and changes only the carry. Results are registered, and they hold their value until the next accepted operation.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero after that edge, including `res_valid`, `acc_we` and `pair_out`.
- R2: An operation sampled with `op_valid` high at a rising edge produces its result, with `res_valid` high, right after the next rising edge. When `op_valid` is low at an edge, `res_valid` is low after that edge and `acc_out`, `cy_out`, `acc_we` and `pair_out` hold their values.
- R3: Add (code 0) gives `acc_out` = A + B. Add with carry (code 1) gives A + B + CY. In both cases `cy_out` is bit 8 of the 9-bit sum and `acc_we` is 1.
- R4: Subtract (code 2) gives A − B. Subtract with borrow (code 3) gives A − B − CY. `cy_out` is 1 exactly when a borrow occurs, which is when B, or B + CY, is unsigned-greater than A. `acc_we` is 1.
- R5: Compare (code 4) sets `cy_out` exactly as subtract would. It leaves `acc_out` equal to A and drives `acc_we` to 0.
- R6: AND (code 5), OR (code 6) and XOR (code 7) give the bitwise result with `acc_we` = 1 and clear `cy_out`.
- R7: Complement accumulator (code 8) gives `acc_out` = ~A with `acc_we` = 1 and leaves `cy_out` equal to CY.
- R8: Complement carry (code 9) gives `cy_out` = ~CY. Set carry (code 10) gives `cy_out` = 1. Both leave `acc_out` equal to A with `acc_we` = 0.
- R9: Rotate left through carry (code 11) gives `acc_out` = {A[6:0], CY} and `cy_out` = A[7]. Rotate right through carry (code 12) gives {CY, A[7:1]} and `cy_out` = A[0]. `acc_we` is 1 for both.
- R10: Rotate left circular (code 13) gives {A[6:0], A[7]} and `cy_out` = A[7]. Rotate right circular (code 14) gives {A[0], A[7:1]} and `cy_out` = A[0]. `acc_we` is 1 for both.
- R11: Pair add (code 15) gives `pair_out` = P + Q modulo 2^16 and `cy_out` = bit 16 of the sum. It leaves `acc_out` equal to A with `acc_we` = 0. `pair_out` changes only on this operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation inputs are valid this cycle |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| acc_in | input | 8 | Current accumulator A |
| opnd_in | input | 8 | Second operand B |
| cy_in | input | 1 | Current carry flag CY |
| pair_a_in | input | 16 | Register pair P for pair add |
| pair_b_in | input | 16 | Register pair Q for pair add |
| res_valid | output | 1 | Result registers were loaded at the last edge |
| acc_out | output | 8 | New accumulator value |
| cy_out | output | 1 | New carry flag |
| acc_we | output | 1 | Accumulator write-back enable |
| pair_out | output | 16 | 16-bit pair sum |

## Verification
Three cases are the hardest to reach from the ports. The first is a borrow that comes only from the incoming carry. The bench reaches it with subtract with borrow on equal operands, once with CY set and once with it clear. The second is the boundary between compare and subtract. Compare is driven with B below A, equal to A and above A, and the bench confirms that the accumulator passes through unchanged each time. The third is the hold behaviour. After a real result, idle cycles present different inputs with `op_valid` low, and the bench confirms that the registered outputs do not move.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CMA  = 4'd8,
    OP_CMC  = 4'd9,
    OP_STC  = 4'd10,
    OP_RLT  = 4'd11,
    OP_RRT  = 4'd12,
    OP_RLC  = 4'd13,
    OP_RRC  = 4'd14,
    OP_PAIR = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          use_cin,
  input  logic          subtract,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int EW = DW + 1;

  logic [EW-1:0] a_ext;
  logic [EW-1:0] b_ext;
  logic [EW-1:0] c_ext;
  logic [EW-1:0] total;

  always_comb begin
    a_ext = {1'b0, a};
    b_ext = {1'b0, b};
    c_ext = {{DW{1'b0}}, cin & use_cin};
    if (subtract) total = a_ext - b_ext - c_ext;
    else          total = a_ext + b_ext + c_ext;
    res  = total[DW-1:0];
    cout = total[DW];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic_sel_e    sel,
  output logic [DW-1:0] res
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      case (sel)
        LG_AND:  res[i] = a[i] & b[i];
        LG_OR:   res[i] = a[i] | b[i];
        LG_XOR:  res[i] = a[i] ^ b[i];
        default: res[i] = ~a[i];
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          left,
  input  logic          thru,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic fill_l;
  logic fill_r;

  assign fill_l = thru ? cin : a[DW-1];
  assign fill_r = thru ? cin : a[0];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_lo
      assign from_low = fill_l;
    end else begin : g_lo
      assign from_low = a[i-1];
    end
    if (i == DW - 1) begin : g_hi
      assign from_high = fill_r;
    end else begin : g_hi
      assign from_high = a[i+1];
    end
    assign res[i] = left ? from_low : from_high;
  end

  assign cout = left ? a[DW-1] : a[0];
endmodule

// File: rtl/acc_alu_pair.sv
module acc_alu_pair #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] p,
  input  logic [PW-1:0] q,
  output logic [PW-1:0] sum,
  output logic          cout
);
  logic [PW:0] total;
  assign total = {1'b0, p} + {1'b0, q};
  assign sum   = total[PW-1:0];
  assign cout  = total[PW];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  input  logic          cy_in,
  input  logic [PW-1:0] pair_a_in,
  input  logic [PW-1:0] pair_b_in,
  output logic          res_valid,
  output logic [DW-1:0] acc_out,
  output logic          cy_out,
  output logic          acc_we,
  output logic [PW-1:0] pair_out
);
  op_e op;
  assign op = op_e'(op_code);

  logic          ar_use_cin;
  logic          ar_sub;
  logic [DW-1:0] ar_res;
  logic          ar_cout;

  assign ar_use_cin = (op == OP_ADC) || (op == OP_SBB);
  assign ar_sub     = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);

  acc_alu_arith #(.DW(DW)) u_arith (
    .a(acc_in), .b(opnd_in), .cin(cy_in), .use_cin(ar_use_cin),
    .subtract(ar_sub), .res(ar_res), .cout(ar_cout)
  );

  logic_sel_e    lg_sel;
  logic [DW-1:0] lg_res;

  always_comb begin
    case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_NOT;
    endcase
  end

  acc_alu_logic #(.DW(DW)) u_logic (
    .a(acc_in), .b(opnd_in), .sel(lg_sel), .res(lg_res)
  );

  logic          rt_left;
  logic          rt_thru;
  logic [DW-1:0] rt_res;
  logic          rt_cout;

  assign rt_left = (op == OP_RLT) || (op == OP_RLC);
  assign rt_thru = (op == OP_RLT) || (op == OP_RRT);

  acc_alu_rotate #(.DW(DW)) u_rot (
    .a(acc_in), .cin(cy_in), .left(rt_left), .thru(rt_thru),
    .res(rt_res), .cout(rt_cout)
  );

  logic [PW-1:0] pr_sum;
  logic          pr_cout;

  acc_alu_pair #(.PW(PW)) u_pair (
    .p(pair_a_in), .q(pair_b_in), .sum(pr_sum), .cout(pr_cout)
  );

  logic [DW-1:0] nx_acc;
  logic          nx_cy;
  logic          nx_we;

  always_comb begin
    nx_acc = acc_in;
    nx_cy  = cy_in;
    nx_we  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        nx_acc = ar_res; nx_cy = ar_cout; nx_we = 1'b1;
      end
      OP_CMP:                 nx_cy = ar_cout;
      OP_AND, OP_OR, OP_XOR: begin
        nx_acc = lg_res; nx_cy = 1'b0; nx_we = 1'b1;
      end
      OP_CMA: begin
        nx_acc = lg_res; nx_we = 1'b1;
      end
      OP_CMC:                 nx_cy = ~cy_in;
      OP_STC:                 nx_cy = 1'b1;
      OP_RLT, OP_RRT, OP_RLC, OP_RRC: begin
        nx_acc = rt_res; nx_cy = rt_cout; nx_we = 1'b1;
      end
      default:                nx_cy = pr_cout;
    endcase
  end

  op_e op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      acc_out   <= '0;
      cy_out    <= 1'b0;
      acc_we    <= 1'b0;
      pair_out  <= '0;
      op_q      <= OP_ADD;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        acc_out <= nx_acc;
        cy_out  <= nx_cy;
        acc_we  <= nx_we;
        op_q    <= op;
        if (op == OP_PAIR) pair_out <= pr_sum;
      end
    end
  end

  // R2: a result appears only for an accepted operation
  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(op_valid));

  // R2: idle cycles keep the registered result
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc_out) && $stable(cy_out) && $stable(pair_out));

  // R5: compare passes the accumulator through without write-back
  p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && op_q == OP_CMP) |-> (!acc_we && acc_out == $past(acc_in)));

  // R6: logic operations leave carry clear
  p_logic_clears_cy_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR)) |-> !cy_out);

  // R8: complement carry inverts the presented carry
  p_cmc_inverts_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && op_q == OP_CMC) |-> (cy_out == !$past(cy_in) && !acc_we));

  // R8: set carry forces carry high
  p_stc_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && op_q == OP_STC) |-> cy_out);

  // R11: pair sum only moves on a pair add
  p_pair_only_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op != OP_PAIR) |=> $stable(pair_out));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [7:0]  acc_in;
  logic [7:0]  opnd_in;
  logic        cy_in;
  logic [15:0] pair_a_in;
  logic [15:0] pair_b_in;
  logic        res_valid;
  logic [7:0]  acc_out;
  logic        cy_out;
  logic        acc_we;
  logic [15:0] pair_out;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in),
    .pair_a_in(pair_a_in), .pair_b_in(pair_b_in),
    .res_valid(res_valid), .acc_out(acc_out), .cy_out(cy_out),
    .acc_we(acc_we), .pair_out(pair_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic c);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = b; cy_in = c;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect8(input string tag, input logic [7:0] ea, input logic ec,
                         input logic ew);
    chk({tag, " valid"}, {31'd0, res_valid}, 32'd1);
    chk({tag, " acc"}, {24'd0, acc_out}, {24'd0, ea});
    chk({tag, " cy"}, {31'd0, cy_out}, {31'd0, ec});
    chk({tag, " we"}, {31'd0, acc_we}, {31'd0, ew});
  endtask

  task automatic t_reset;
    rst = 1'b1; op_valid = 1'b0; op_code = 4'd0; acc_in = 8'h00; opnd_in = 8'h00;
    cy_in = 1'b0; pair_a_in = 16'h0; pair_b_in = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, res_valid}, 32'd0);
    chk("R1 acc", {24'd0, acc_out}, 32'd0);
    chk("R1 cy", {31'd0, cy_out}, 32'd0);
    chk("R1 we", {31'd0, acc_we}, 32'd0);
    chk("R1 pair", {16'd0, pair_out}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_add;
    run_op(4'd0, 8'h98, 8'h65, 1'b1); expect8("R3 add", 8'hFD, 1'b0, 1'b1);
    run_op(4'd0, 8'hC8, 8'h50, 1'b0); expect8("R3 add carry", 8'h18, 1'b1, 1'b1);
    run_op(4'd1, 8'h98, 8'h65, 1'b1); expect8("R3 adc", 8'hFE, 1'b0, 1'b1);
    run_op(4'd1, 8'hFF, 8'h00, 1'b1); expect8("R3 adc wrap", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_sub;
    run_op(4'd2, 8'h50, 8'h20, 1'b1); expect8("R4 sub", 8'h30, 1'b0, 1'b1);
    run_op(4'd2, 8'h20, 8'h50, 1'b0); expect8("R4 sub borrow", 8'hD0, 1'b1, 1'b1);
    run_op(4'd3, 8'h50, 8'h20, 1'b1); expect8("R4 sbb", 8'h2F, 1'b0, 1'b1);
    run_op(4'd3, 8'h33, 8'h33, 1'b1); expect8("R4 sbb cy borrow", 8'hFF, 1'b1, 1'b1);
    run_op(4'd3, 8'h33, 8'h33, 1'b0); expect8("R4 sbb equal", 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_cmp;
    run_op(4'd4, 8'h20, 8'h50, 1'b0); expect8("R5 cmp above", 8'h20, 1'b1, 1'b0);
    run_op(4'd4, 8'h50, 8'h50, 1'b1); expect8("R5 cmp equal", 8'h50, 1'b0, 1'b0);
    run_op(4'd4, 8'h50, 8'h20, 1'b1); expect8("R5 cmp below", 8'h50, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    run_op(4'd5, 8'hF0, 8'h3C, 1'b1); expect8("R6 and", 8'h30, 1'b0, 1'b1);
    run_op(4'd6, 8'hF0, 8'h0F, 1'b1); expect8("R6 or", 8'hFF, 1'b0, 1'b1);
    run_op(4'd7, 8'hAA, 8'hFF, 1'b1); expect8("R6 xor", 8'h55, 1'b0, 1'b1);
  endtask

  task automatic t_carry_ops;
    run_op(4'd8, 8'h5A, 8'h00, 1'b1); expect8("R7 cma", 8'hA5, 1'b1, 1'b1);
    run_op(4'd8, 8'hFF, 8'h12, 1'b0); expect8("R7 cma cy0", 8'h00, 1'b0, 1'b1);
    run_op(4'd9, 8'h42, 8'h00, 1'b1); expect8("R8 cmc 1", 8'h42, 1'b0, 1'b0);
    run_op(4'd9, 8'h42, 8'h00, 1'b0); expect8("R8 cmc 0", 8'h42, 1'b1, 1'b0);
    run_op(4'd10, 8'h77, 8'h00, 1'b0); expect8("R8 stc", 8'h77, 1'b1, 1'b0);
  endtask

  task automatic t_rotates;
    run_op(4'd11, 8'h88, 8'h00, 1'b1); expect8("R9 rlt", 8'h11, 1'b1, 1'b1);
    run_op(4'd11, 8'h40, 8'h00, 1'b0); expect8("R9 rlt cy0", 8'h80, 1'b0, 1'b1);
    run_op(4'd12, 8'h01, 8'h00, 1'b0); expect8("R9 rrt", 8'h00, 1'b1, 1'b1);
    run_op(4'd12, 8'h10, 8'h00, 1'b1); expect8("R9 rrt cy1", 8'h88, 1'b0, 1'b1);
    run_op(4'd13, 8'h88, 8'h00, 1'b0); expect8("R10 rlc", 8'h11, 1'b1, 1'b1);
    run_op(4'd13, 8'h41, 8'h00, 1'b1); expect8("R10 rlc cy1", 8'h82, 1'b0, 1'b1);
    run_op(4'd14, 8'h01, 8'h00, 1'b0); expect8("R10 rrc", 8'h80, 1'b1, 1'b1);
    run_op(4'd14, 8'h02, 8'h00, 1'b1); expect8("R10 rrc cy1", 8'h01, 1'b0, 1'b1);
  endtask

  task automatic t_pair;
    pair_a_in = 16'h2050; pair_b_in = 16'h2050;
    run_op(4'd15, 8'h3C, 8'h00, 1'b1); expect8("R11 pair", 8'h3C, 1'b0, 1'b0);
    chk("R11 pair sum", {16'd0, pair_out}, 32'h40A0);
    pair_a_in = 16'hFFFF; pair_b_in = 16'h0001;
    run_op(4'd15, 8'h3C, 8'h00, 1'b0); expect8("R11 pair carry", 8'h3C, 1'b1, 1'b0);
    chk("R11 pair wrap", {16'd0, pair_out}, 32'h0000);
    pair_a_in = 16'h1111; pair_b_in = 16'h2222;
    run_op(4'd0, 8'h01, 8'h01, 1'b0); expect8("R11 other op", 8'h02, 1'b0, 1'b1);
    chk("R11 pair unchanged", {16'd0, pair_out}, 32'h0000);
  endtask

  task automatic t_idle;
    run_op(4'd2, 8'h20, 8'h50, 1'b0); expect8("R2 setup", 8'hD0, 1'b1, 1'b1);
    op_code = 4'd15; acc_in = 8'h01; opnd_in = 8'h01; cy_in = 1'b0;
    pair_a_in = 16'h0100; pair_b_in = 16'h0100;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, res_valid}, 32'd0);
    chk("R2 idle acc", {24'd0, acc_out}, 32'hD0);
    chk("R2 idle cy", {31'd0, cy_out}, 32'd1);
    chk("R2 idle we", {31'd0, acc_we}, 32'd1);
    chk("R2 idle pair", {16'd0, pair_out}, 32'h0000);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_carry_ops();
    t_rotates();
    t_pair();
    t_idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again valid", {31'd0, res_valid}, 32'd0);
    chk("R1 reset again acc", {24'd0, acc_out}, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule